// File: doc/BRIEF.md
# Tagged-Word Serial Receiver

This block is the receive half of an asynchronous serial port. The serial input is sampled on a 16x oversampling tick supplied from outside. A falling edge starts a candidate frame, and the block confirms it at mid-bit. It then gathers 5 to 9 data bits, least significant bit first. An optional even or odd parity bit and a stop bit follow. Each finished character is stored as one 16-bit word that carries its parity and framing error bits beside the data.

The stored words go into a two-deep first-in first-out buffer. A level output shows that at least one word is waiting. Pulsing the pop input removes the word shown on the read port. Two sticky interrupt flags are kept: one for "a word was stored" and one for "a word was lost because the buffer was full". Software can clear or set each flag with one-bit write strobes. Separate command pulses turn the receiver on and off.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `rx_enabled`, `data_valid`, `irq_flags` and `rd_word` are all zero, and the line is treated as idle (high).
- R2: The data length is `cfg_bits`, clamped to the range 5..9. Data bits arrive least significant bit first. They appear in `rd_word[8:0]`, and bits above the configured length read as 0.
- R3: `cfg_par` selects the parity mode: 2'b0x means none, 2'b10 means even, 2'b11 means odd. A parity bit that does not match the chosen parity over the data bits sets `rd_word[14]`.
- R4: Only the first stop bit is sampled. If it is low, `rd_word[15]` is set. `rd_word[13:9]` always reads 0. Hunting for the next start bit resumes at the middle of the first stop bit, so frames with a single stop bit can follow each other directly.
- R5: A line held low for a whole frame and beyond (a break) stores exactly one word. With parity off this word is 16'h8000. No further word is stored until the line has gone high again.
- R6: A start bit is accepted only if the line is still low at the 8th tick after the falling edge. Otherwise the receiver goes back to hunting and stores nothing.
- R7: The buffer holds 2 words in arrival order. `data_valid` is high while it is not empty. A `rd_pop` pulse removes the head word, and `rd_word` reads 0 when the buffer is empty.
- R8: A frame that completes while the buffer is full is discarded, the stored words are kept, and `irq_flags[1]` (overflow) is set.
- R9: `irq_flags[0]` is set whenever a word is stored. A 1 in `flag_clr` clears the matching flag, and a 1 in `flag_set` sets it. Set and hardware events win over clear in the same cycle.
- R10: `cmd_rx_on` enables the receiver and `cmd_rx_off` disables it, and off wins when both are pulsed together. While disabled, the line is ignored and the buffer contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial input line |
| cmd_rx_on | input | 1 | Enable pulse |
| cmd_rx_off | input | 1 | Disable pulse |
| cfg_bits | input | 4 | Data bits per frame (5..9) |
| cfg_par | input | 2 | Parity mode |
| rd_pop | input | 1 | Pop the head word |
| flag_clr | input | 2 | Flag clear strobes |
| flag_set | input | 2 | Flag set strobes |
| rd_word | output | 16 | Head word {ferr, perr, 5'b0, data[8:0]} |
| data_valid | output | 1 | Buffer not empty |
| irq_flags | output | 2 | {overflow, word stored} |
| rx_enabled | output | 1 | Receiver enabled |

## Verification
Random frames vary the data length, the parity mode and the data values. Some of them carry a flipped parity bit or a low stop bit, which separates errors in bit order, length masking, parity polarity and stop sampling. A few of these frames run at half the tick rate to show that only ticked cycles advance the sampler. Directed patterns cover the remaining cases: a short low glitch (start rejection), a long low break (one word, then a wait for high), back-to-back frames with a single stop bit, a third frame into a full buffer, and frames sent while disabled.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int DATA_W = 9;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rx_state_e;

  // Bring a requested data length into the supported 5..9 range.
  function automatic logic [3:0] clamp_bits(input logic [3:0] b);
    if (b < 4'd5) return 4'd5;
    if (b > 4'd9) return 4'd9;
    return b;
  endfunction

  // Parity bit a sender must transmit; odd=1 selects odd parity.
  function automatic logic par_expect(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Stored word: framing error on top, parity error below it, data at the bottom.
  function automatic logic [WORD_W-1:0] pack_word(input logic [DATA_W-1:0] d,
                                                  input logic pe, input logic fe);
    return {fe, pe, 5'b0, d};
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], rxd};
  end

  assign line = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic [3:0]        cfg_bits,
  input  logic [1:0]        cfg_par,
  output logic              frame_done,
  output logic [WORD_W-1:0] frame_word
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] data_q;
  logic              perr_q;
  logic [3:0]        nbits;
  logic              mid_tick;
  logic              bit_tick;

  assign nbits    = clamp_bits(cfg_bits);
  assign mid_tick = tick && (cnt_q == CW'(MID - 1));
  assign bit_tick = tick && (cnt_q == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_HUNT;
      cnt_q      <= '0;
      idx_q      <= '0;
      data_q     <= '0;
      perr_q     <= 1'b0;
      frame_done <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!en) begin
        state_q <= S_HUNT;
      end else begin
        case (state_q)
          S_HUNT: if (tick && !line) begin
            state_q <= S_START;
            cnt_q   <= CW'(1);
          end
          S_START: if (tick) begin
            if (mid_tick) begin
              if (line) state_q <= S_HUNT;
              else begin
                state_q <= S_DATA;
                cnt_q   <= '0;
                idx_q   <= '0;
                data_q  <= '0;
                perr_q  <= 1'b0;
              end
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_DATA: if (tick) begin
            if (bit_tick) begin
              cnt_q         <= '0;
              data_q[idx_q] <= line;
              idx_q         <= idx_q + 4'd1;
              if (idx_q == nbits - 4'd1) state_q <= cfg_par[1] ? S_PAR : S_STOP;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_PAR: if (tick) begin
            if (bit_tick) begin
              cnt_q   <= '0;
              perr_q  <= line != par_expect(data_q, cfg_par[0]);
              state_q <= S_STOP;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_STOP: if (tick) begin
            if (bit_tick) begin
              cnt_q      <= '0;
              frame_done <= 1'b1;
              frame_word <= pack_word(data_q, perr_q, !line);
              state_q    <= line ? S_HUNT : S_WAITHI;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_WAITHI: if (line) state_q <= S_HUNT;
          default: state_q <= S_HUNT;
        endcase
      end
    end
  end

  // R6: a start that is high again at mid-bit is dropped
  assert_start_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == S_START && mid_tick && line) |=> state_q == S_HUNT);
  // R4: a low first stop bit yields a word tagged with a framing error
  assert_stop_ferr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == S_STOP && bit_tick && !line) |=> (frame_done && frame_word[15]));
  // R2: one completion pulse per frame
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/rx_store.sv
module rx_store
  import rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  input  logic [1:0]        flag_clr,
  input  logic [1:0]        flag_set,
  output logic [WORD_W-1:0] rd_word,
  output logic              data_valid,
  output logic [1:0]        irq_flags
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [NW-1:0]     count_q;
  logic              full, pop_ok, accept, ovf;

  assign full       = count_q == NW'(DEPTH);
  assign pop_ok     = pop && (count_q != '0);
  assign accept     = push && (!full || pop);
  assign ovf        = push && full && !pop;
  assign data_valid = count_q != '0;
  assign rd_word    = data_valid ? mem[rd_q] : '0;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= '0;
      rd_q      <= '0;
      count_q   <= '0;
      irq_flags <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (accept) begin
        mem[wr_q] <= push_word;
        wr_q      <= next_ptr(wr_q);
      end
      if (pop_ok) rd_q <= next_ptr(rd_q);
      count_q   <= count_q + NW'(accept) - NW'(pop_ok);
      irq_flags <= (irq_flags & ~flag_clr) | flag_set | {ovf, accept};
    end
  end

  // R8: a word into a full buffer is dropped and flagged
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count_q == NW'(DEPTH) && irq_flags[1]));
  // R7: occupancy never exceeds the depth
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= NW'(DEPTH));
  // R7: popping the last word empties the buffer
  assert_pop_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count_q == NW'(1) && !push) |=> !data_valid);
  // R9: a set strobe always lands
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[0] |=> irq_flags[0]);
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rxd,
  input  logic        cmd_rx_on,
  input  logic        cmd_rx_off,
  input  logic [3:0]  cfg_bits,
  input  logic [1:0]  cfg_par,
  input  logic        rd_pop,
  input  logic [1:0]  flag_clr,
  input  logic [1:0]  flag_set,
  output logic [15:0] rd_word,
  output logic        data_valid,
  output logic [1:0]  irq_flags,
  output logic        rx_enabled
);
  logic              line;
  logic              frame_done;
  logic [WORD_W-1:0] frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_enabled <= 1'b0;
    else if (cmd_rx_off) rx_enabled <= 1'b0;
    else if (cmd_rx_on)  rx_enabled <= 1'b1;
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line)
  );

  rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_enabled), .tick(tick16), .line(line),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(frame_done), .push_word(frame_word),
    .pop(rd_pop), .flag_clr(flag_clr), .flag_set(flag_set),
    .rd_word(rd_word), .data_valid(data_valid), .irq_flags(irq_flags)
  );

  // R10: the off command wins and disables the receiver
  assert_off_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_off |=> !rx_enabled);
endmodule

// File: tb/sim_uart_rx_tagged.sv
module sim_uart_rx_tagged;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick16 = 0;
  logic        rxd = 1;
  logic        cmd_rx_on = 0, cmd_rx_off = 0;
  logic [3:0]  cfg_bits = 4'd8;
  logic [1:0]  cfg_par = 2'b00;
  logic        rd_pop = 0;
  logic [1:0]  flag_clr = 0, flag_set = 0;
  logic [15:0] rd_word;
  logic        data_valid;
  logic [1:0]  irq_flags;
  logic        rx_enabled;

  int n_chk = 0, n_bad = 0;
  int tpc = 1;
  int tcnt = 0;

  uart_rx_tagged u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .rd_pop(rd_pop),
    .flag_clr(flag_clr), .flag_set(flag_set),
    .rd_word(rd_word), .data_valid(data_valid), .irq_flags(irq_flags),
    .rx_enabled(rx_enabled)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tpc - 1) begin tcnt <= 0; tick16 <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick16 <= 1'b0; end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [8:0] len_mask(input int nb);
    return 9'((10'd1 << nb) - 10'd1);
  endfunction

  // Expected stored word, built from the field layout of R2..R4.
  function automatic logic [15:0] model_word(input logic [8:0] d, input int nb,
                                             input logic [1:0] pm, input bit flip,
                                             input bit stop_low);
    logic [15:0] w;
    w = 16'h0;
    w[8:0] = d & len_mask(nb);
    w[14]  = pm[1] & flip;
    w[15]  = stop_low;
    return w;
  endfunction

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (16 * tpc) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input logic [1:0] pm,
                            input bit flip, input bit stop_low, input int idle_bits);
    logic [8:0] m;
    logic p;
    m = d & len_mask(nb);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(m[i]);
    if (pm[1]) begin
      p = (^m) ^ pm[0] ^ flip;
      drive_bit(p);
    end
    drive_bit(!stop_low);
    rxd = 1'b1;
    for (int i = 0; i < idle_bits; i++) drive_bit(1'b1);
  endtask

  task automatic pop_word();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_flags(input logic [1:0] c, input logic [1:0] s);
    flag_clr = c; flag_set = s;
    @(negedge clk);
    flag_clr = 2'b00; flag_set = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] d, a, b, c;
    int nb;
    logic [1:0] pm;
    bit flip, sl;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rx_enabled", {15'b0, rx_enabled}, 16'h0);
    chk("R1 data_valid", {15'b0, data_valid}, 16'h0);
    chk("R1 irq_flags", {14'b0, irq_flags}, 16'h0);
    chk("R1 rd_word", rd_word, 16'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cmd_rx_on = 1; @(negedge clk); cmd_rx_on = 0; @(negedge clk);
    chk("R10 enable", {15'b0, rx_enabled}, 16'h1);
    drive_bit(1'b1);

    // Random frames: R2 length/order, R3 parity, R4 stop check, R9 flag
    for (int i = 0; i < 30; i++) begin
      nb = 5 + int'($urandom_range(0, 4));
      case ($urandom_range(0, 3))
        0: pm = 2'b00; 1: pm = 2'b01; 2: pm = 2'b10; default: pm = 2'b11;
      endcase
      d    = 9'($urandom);
      flip = ($urandom_range(0, 3) == 0);
      sl   = ($urandom_range(0, 7) == 0);
      tpc  = (i % 5 == 4) ? 2 : 1;
      cfg_bits = 4'(nb); cfg_par = pm;
      send_frame(d, nb, pm, flip, sl, 1);
      chk("R7 valid after frame", {15'b0, data_valid}, 16'h1);
      chk("R2/R3/R4 word", rd_word, model_word(d, nb, pm, flip, sl));
      chk("R9 stored flag", {15'b0, irq_flags[0]}, 16'h1);
      pop_word();
      chk("R7 empty after pop", {15'b0, data_valid}, 16'h0);
      pulse_flags(2'b11, 2'b00);
    end
    tpc = 1;

    // R2: out-of-range length clamps to 9 and 5
    cfg_par = 2'b00; cfg_bits = 4'd15;
    send_frame(9'h1A5, 9, 2'b00, 0, 0, 1);
    chk("R2 clamp high", rd_word, 16'h01A5);
    pop_word();
    cfg_bits = 4'd2;
    send_frame(9'h1FF, 5, 2'b00, 0, 0, 1);
    chk("R2 clamp low", rd_word, 16'h001F);
    pop_word();

    // R6: short low glitch is rejected
    cfg_bits = 4'd8;
    rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    drive_bit(1'b1); drive_bit(1'b1);
    chk("R6 glitch ignored", {15'b0, data_valid}, 16'h0);

    // R5: break gives one word 0x8000 and waits for high
    pulse_flags(2'b11, 2'b00);
    rxd = 0; repeat (16 * 30) @(negedge clk);
    chk("R5 break word", rd_word, 16'h8000);
    pop_word();
    repeat (16 * 12) @(negedge clk);
    chk("R5 single break word", {15'b0, data_valid}, 16'h0);
    rxd = 1; drive_bit(1'b1); drive_bit(1'b1);
    chk("R5 none after release", {15'b0, data_valid}, 16'h0);

    // R4: back-to-back frames with a single stop bit
    a = 9'h0C3; b = 9'h03C;
    send_frame(a, 8, 2'b00, 0, 0, 0);
    send_frame(b, 8, 2'b00, 0, 0, 1);
    chk("R4 b2b first", rd_word, 16'h00C3);
    pop_word();
    chk("R4 b2b second", rd_word, 16'h003C);
    pop_word();

    // R8: third frame into full buffer is dropped
    pulse_flags(2'b11, 2'b00);
    a = 9'h011; b = 9'h022; c = 9'h033;
    send_frame(a, 8, 2'b00, 0, 0, 1);
    send_frame(b, 8, 2'b00, 0, 0, 1);
    chk("R8 no overflow yet", {15'b0, irq_flags[1]}, 16'h0);
    send_frame(c, 8, 2'b00, 0, 0, 1);
    chk("R8 overflow flag", {15'b0, irq_flags[1]}, 16'h1);
    chk("R8 head kept", rd_word, 16'h0011);
    pop_word();
    chk("R8 second kept", rd_word, 16'h0022);
    pop_word();
    chk("R7 empty reads zero", rd_word, 16'h0000);
    chk("R7 empty valid", {15'b0, data_valid}, 16'h0);

    // R9: clear, set, set-beats-clear
    pulse_flags(2'b11, 2'b00);
    chk("R9 cleared", {14'b0, irq_flags}, 16'h0);
    pulse_flags(2'b00, 2'b10);
    chk("R9 set overflow", {14'b0, irq_flags}, 16'h2);
    pulse_flags(2'b01, 2'b01);
    chk("R9 set wins", {14'b0, irq_flags}, 16'h3);
    pulse_flags(2'b10, 2'b00);
    chk("R9 clear one", {14'b0, irq_flags}, 16'h1);
    pulse_flags(2'b11, 2'b00);

    // R10: disabled receiver ignores the line, buffer kept, off wins
    send_frame(9'h055, 8, 2'b00, 0, 0, 1);
    cmd_rx_on = 1; cmd_rx_off = 1; @(negedge clk);
    cmd_rx_on = 0; cmd_rx_off = 0; @(negedge clk);
    chk("R10 off wins", {15'b0, rx_enabled}, 16'h0);
    send_frame(9'h0AA, 8, 2'b00, 0, 0, 1);
    chk("R10 buffer kept", rd_word, 16'h0055);
    pop_word();
    chk("R10 frame ignored", {15'b0, data_valid}, 16'h0);
    cmd_rx_on = 1; @(negedge clk); cmd_rx_on = 0; @(negedge clk);
    send_frame(9'h0AA, 8, 2'b00, 0, 0, 1);
    chk("R10 re-enabled", rd_word, 16'h00AA);
    pop_word();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule